// File: doc/BRIEF.md
# Fourier Moving-Average Fundamental Extractor

This block recovers the fundamental-frequency part of one phase-voltage sample stream. Each sample is multiplied by a sine reference and a cosine reference. Both references come from an internal table that steps once per sample, and one pass through the table covers exactly one fundamental period. Each of the two products feeds a running-sum average whose window holds one period of samples, so only the DC part of each product is left. Those two averages are multiplied by the references again and combined. This yields the fundamental twice: once in sine form, which follows the input, and once in cosine form, a quarter period ahead.

One instance serves one phase. A three-phase system uses three instances with a shared strobe, so every phase is tracked on its own. Unequal amplitudes or phase shifts between the phases do not disturb the result. The phase offset between the internal reference and the grid may be anything. Turning the two outputs into an angle is left to the logic downstream.

Top module: `fund_mavg_extract`

## Requirements
- R1: A synchronous active-low reset clears `fund_sin`, `fund_cos` and `fund_vld` to zero. It also returns the table index to 0, clears the averaging history to zero products and clears the count of strobes.
- R2: The reference table holds `S[k]` for k = 0..N-1. With A = 2^(RW-1)-1, h = N/2 and j = k mod h, S[k] = floor(A*16*j*(h-j) / (5*h*h - 4*j*(h-j))), and it is negated when k >= h. The cosine reference is `S[(k+N/4) mod N]`. The index k starts at 0 and advances by one, modulo N, on every strobe. N is a power of two, at least 4.
- R3: On a strobe, the products `smp_in*S[k]` and `smp_in*C[k]` enter two windows that each hold the N most recent products. Slots not yet filled count as zero. Each average equals the window sum shifted arithmetically right by log2(N).
- R4: Two clock edges after the edge that samples a strobe, `fund_sin` holds the low OW bits of (avgS*S[k] + avgC*C[k]) >>> (2*RW-3). Here k is the index that strobe used.
- R5: In the same cycle, `fund_cos` holds the low OW bits of (avgS*C[k] - avgC*S[k]) >>> (2*RW-3).
- R6: `fund_vld` pulses for one cycle, aligned with the output update, only for the N-th strobe since reset and for every strobe after it. Earlier strobes still update the outputs, but leave `fund_vld` low.
- R7: In a cycle with no strobe, input sample values are ignored. The outputs hold their values, `fund_vld` is low, and neither the index nor the windows move.
- R8: Once a full period of an input tone at the table frequency has been taken in, `fund_sin` matches that tone within 16 LSB. `fund_cos` matches its quarter-period-advanced copy within 16 LSB.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| smp_stb | input | 1 | Qualifies `smp_in` for this cycle |
| smp_in | input | DW | Signed phase-voltage sample |
| fund_sin | output | OW | Signed fundamental, sine form |
| fund_cos | output | OW | Signed fundamental, cosine form |
| fund_vld | output | 1 | Output update after the windows have filled |

## Verification
The case that needs care is a single strobe that drops the oldest product from a window and adds the newest one. When that strobe is the N-th, the first valid flag is raised in the same update, and the table index wraps back to 0 at that point too. The bench provokes this with unbroken runs of strobes and with runs broken by random gaps. Such runs cross the fill point and several table wraps, after reset and again after a reset in mid-run. Each update is judged against a bit-exact model of the window sums and the output formulas, and the flag is checked against the count of strobes.

// File: rtl/fme_pkg.sv
package fme_pkg;

    // Integer sine code for table slot k of an n-entry period at rw bits.
    function automatic int sine_code(int k, int n, int rw);
        longint half;
        longint j;
        longint amp;
        longint num;
        longint den;
        longint v;
        half = longint'(n / 2);
        j    = longint'(k) % half;
        amp  = (longint'(1) << (rw - 1)) - 1;
        num  = 16 * j * (half - j);
        den  = 5 * half * half - 4 * j * (half - j);
        v    = (amp * num) / den;
        if ((k % n) >= (n / 2)) begin
            v = -v;
        end
        return int'(v);
    endfunction

endpackage

// File: rtl/fme_ref_rom.sv
module fme_ref_rom #(
    parameter int N  = 64,
    parameter int RW = 12,
    localparam int AW = $clog2(N)
) (
    input  logic [AW-1:0]        idx,
    output logic signed [RW-1:0] sin_o,
    output logic signed [RW-1:0] cos_o
);
    localparam logic [AW-1:0] QTR = AW'(N / 4);

    logic signed [RW-1:0] tbl [N];
    logic [AW-1:0]        cidx;

    for (genvar g = 0; g < N; g++) begin : g_tbl
        localparam int VAL = fme_pkg::sine_code(g, N, RW);
        assign tbl[g] = RW'(VAL);
    end

    assign cidx  = idx + QTR;
    assign sin_o = tbl[idx];
    assign cos_o = tbl[cidx];
endmodule

// File: rtl/fme_mavg.sv
module fme_mavg #(
    parameter int N  = 64,
    parameter int PW = 24
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 push,
    input  logic signed [PW-1:0] din,
    output logic signed [PW-1:0] avg_o
);
    localparam int AW = $clog2(N);
    localparam int SW = PW + AW;

    typedef struct packed {
        logic [AW-1:0] ptr;
        logic [SW-1:0] sum;
    } mav_st_t;

    mav_st_t              st_d, st_q;
    logic signed [PW-1:0] hist_q [N];
    logic signed [PW-1:0] oldest;

    assign oldest = hist_q[st_q.ptr];

    always_comb begin
        st_d = st_q;
        if (push) begin
            st_d.sum = SW'($signed(st_q.sum) + SW'(din) - SW'(oldest));
            st_d.ptr = st_q.ptr + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    // History slots are written in place; only the slot under the pointer moves.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < N; i++) begin
                hist_q[i] <= '0;
            end
        end else if (push) begin
            hist_q[st_q.ptr] <= din;
        end
    end

    assign avg_o = PW'($signed(st_q.sum) >>> AW);
endmodule

// File: rtl/fme_remod.sv
module fme_remod #(
    parameter int PW = 24,
    parameter int RW = 12,
    parameter int OW = 14
) (
    input  logic signed [PW-1:0] avg_s,
    input  logic signed [PW-1:0] avg_c,
    input  logic signed [RW-1:0] ref_s,
    input  logic signed [RW-1:0] ref_c,
    output logic signed [OW-1:0] y_sin,
    output logic signed [OW-1:0] y_cos
);
    localparam int MW = PW + RW + 1;
    localparam int SH = 2 * RW - 3;

    logic signed [MW-1:0] acc_s, acc_c;

    // The x2 of the remodulation is folded into the shift (one less than 2*(RW-1)).
    assign acc_s = MW'(avg_s) * MW'(ref_s) + MW'(avg_c) * MW'(ref_c);
    assign acc_c = MW'(avg_s) * MW'(ref_c) - MW'(avg_c) * MW'(ref_s);
    assign y_sin = OW'(acc_s >>> SH);
    assign y_cos = OW'(acc_c >>> SH);
endmodule

// File: rtl/fund_mavg_extract.sv
module fund_mavg_extract #(
    parameter int DW = 12,
    parameter int RW = 12,
    parameter int N  = 64,
    parameter int OW = DW + 2
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 smp_stb,
    input  logic signed [DW-1:0] smp_in,
    output logic signed [OW-1:0] fund_sin,
    output logic signed [OW-1:0] fund_cos,
    output logic                 fund_vld
);
    localparam int AW = $clog2(N);
    localparam int PW = DW + RW;
    localparam int CW = AW + 1;

    typedef struct packed {
        logic [AW-1:0] ph;
        logic [AW-1:0] ph_rem;
        logic [CW-1:0] cnt;
        logic          go;
        logic          full;
        logic [OW-1:0] ys;
        logic [OW-1:0] yc;
        logic          vld;
    } top_st_t;

    top_st_t st_d, st_q;

    logic signed [RW-1:0] rs_now, rc_now, rs_rem, rc_rem;
    logic signed [PW-1:0] prod [2];
    logic signed [PW-1:0] avg  [2];
    logic signed [OW-1:0] rem_s, rem_c;

    fme_ref_rom #(.N(N), .RW(RW)) u_ref_now (
        .idx   (st_q.ph),
        .sin_o (rs_now),
        .cos_o (rc_now)
    );

    fme_ref_rom #(.N(N), .RW(RW)) u_ref_rem (
        .idx   (st_q.ph_rem),
        .sin_o (rs_rem),
        .cos_o (rc_rem)
    );

    assign prod[0] = PW'(smp_in) * PW'(rs_now);
    assign prod[1] = PW'(smp_in) * PW'(rc_now);

    for (genvar g = 0; g < 2; g++) begin : g_chan
        fme_mavg #(.N(N), .PW(PW)) u_mavg (
            .clk   (clk),
            .rst_n (rst_n),
            .push  (smp_stb),
            .din   (prod[g]),
            .avg_o (avg[g])
        );
    end

    fme_remod #(.PW(PW), .RW(RW), .OW(OW)) u_remod (
        .avg_s (avg[0]),
        .avg_c (avg[1]),
        .ref_s (rs_rem),
        .ref_c (rc_rem),
        .y_sin (rem_s),
        .y_cos (rem_c)
    );

    always_comb begin
        st_d     = st_q;
        st_d.go  = 1'b0;
        st_d.vld = 1'b0;
        if (smp_stb) begin
            st_d.ph     = st_q.ph + 1'b1;
            st_d.ph_rem = st_q.ph;
            st_d.go     = 1'b1;
            st_d.full   = (st_q.cnt >= CW'(N - 1));
            if (st_q.cnt != CW'(N)) begin
                st_d.cnt = st_q.cnt + 1'b1;
            end
        end
        if (st_q.go) begin
            st_d.ys  = rem_s;
            st_d.yc  = rem_c;
            st_d.vld = st_q.full;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign fund_sin = st_q.ys;
    assign fund_cos = st_q.yc;
    assign fund_vld = st_q.vld;
endmodule

// File: rtl/fme_checker.sv
module fme_checker #(
    parameter int N  = 64,
    parameter int OW = 14
) (
    input logic          clk,
    input logic          rst_n,
    input logic          smp_stb,
    input logic [OW-1:0] fund_sin,
    input logic [OW-1:0] fund_cos,
    input logic          fund_vld
);
    localparam int CW = $clog2(N) + 1;

    logic [CW-1:0] seen_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            seen_q <= '0;
        end else if (smp_stb && seen_q != CW'(N)) begin
            seen_q <= seen_q + 1'b1;
        end
    end

    a_r1_reset_clear: assert property (@(posedge clk) disable iff (!rst_n)
        $past(!rst_n) |-> (!fund_vld && fund_sin == '0 && fund_cos == '0));

    a_r6_valid_needs_fill: assert property (@(posedge clk) disable iff (!rst_n)
        fund_vld |-> (seen_q >= CW'(N)));

    a_r4_valid_after_strobe: assert property (@(posedge clk) disable iff (!rst_n)
        fund_vld |-> $past(smp_stb, 2));

    a_r7_hold_idle: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(smp_stb, 2) |-> ($stable(fund_sin) && $stable(fund_cos) && !fund_vld));
endmodule

bind fund_mavg_extract fme_checker #(.N(N), .OW(OW)) u_fme_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .smp_stb  (smp_stb),
    .fund_sin (fund_sin),
    .fund_cos (fund_cos),
    .fund_vld (fund_vld)
);

// File: tb/fund_mavg_extract_tb_top.sv
module fund_mavg_extract_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int DW = 12;
    localparam int RW = 12;
    localparam int N  = 64;
    localparam int OW = DW + 2;
    localparam int LG = $clog2(N);
    localparam int SH = 2 * RW - 3;

    logic                 clk = 1'b0;
    logic                 rst_n = 1'b0;
    logic                 smp_stb = 1'b0;
    logic signed [DW-1:0] smp_in = '0;
    logic signed [OW-1:0] fund_sin, fund_cos;
    logic                 fund_vld;

    int n_chk = 0;
    int n_bad = 0;

    // Reference model state
    longint hs [N];
    longint hc [N];
    longint sum_s, sum_c;
    int     ph, cnt;
    bit     pend_go;
    logic [OW-1:0] pend_ys, pend_yc;
    bit     pend_full, pend_tol;
    longint pend_fs, pend_fc;
    logic [OW-1:0] exp_ys, exp_yc;

    fund_mavg_extract #(.DW(DW), .RW(RW), .N(N), .OW(OW)) dut_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .smp_stb  (smp_stb),
        .smp_in   (smp_in),
        .fund_sin (fund_sin),
        .fund_cos (fund_cos),
        .fund_vld (fund_vld)
    );

    always #(CLK_PERIOD / 2) clk = ~clk;

    function automatic longint ref_s(int k);
        longint h;
        longint j;
        longint a;
        longint v;
        int     kk;
        kk = k % N;
        h  = N / 2;
        j  = kk % h;
        a  = (longint'(1) << (RW - 1)) - 1;
        v  = (a * 16 * j * (h - j)) / (5 * h * h - 4 * j * (h - j));
        if (kk >= h) v = -v;
        return v;
    endfunction

    function automatic longint tone(int k, int amp);
        return (ref_s(k) * amp) / ((longint'(1) << (RW - 1)) - 1);
    endfunction

    task automatic check(input string tag, input longint act, input longint exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic model_reset();
        for (int i = 0; i < N; i++) begin
            hs[i] = 0;
            hc[i] = 0;
        end
        sum_s = 0; sum_c = 0; ph = 0; cnt = 0;
        pend_go = 0; pend_full = 0; pend_tol = 0;
        exp_ys = '0; exp_yc = '0;
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        smp_stb = 1'b0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        model_reset();
        // R1: cleared outputs while reset is held
        check("R1 fund_vld", longint'(fund_vld), 0);
        check("R1 fund_sin", longint'(fund_sin), 0);
        check("R1 fund_cos", longint'(fund_cos), 0);
        rst_n = 1'b1;
    endtask

    // One clock: drive inputs, take the edge, update the model, check at the next negedge.
    task automatic tick(input bit stb, input longint x, input bit tol,
                        input longint fs, input longint fc);
        bit            now_go;
        logic [OW-1:0] now_ys, now_yc;
        bit            now_full;
        smp_stb = stb;
        smp_in  = DW'(x);
        now_go = 0; now_ys = '0; now_yc = '0; now_full = 0;
        @(posedge clk);
        if (stb) begin
            longint s, c, ps, pc, as, ac;
            longint xs;
            xs = longint'(smp_in);
            s  = ref_s(ph);
            c  = ref_s((ph + N / 4) % N);
            ps = xs * s;
            pc = xs * c;
            sum_s = sum_s + ps - hs[ph];
            sum_c = sum_c + pc - hc[ph];
            hs[ph] = ps;
            hc[ph] = pc;
            ph = (ph + 1) % N;
            if (cnt < N) cnt++;
            as = sum_s >>> LG;
            ac = sum_c >>> LG;
            now_ys   = OW'((as * s + ac * c) >>> SH);
            now_yc   = OW'((as * c - ac * s) >>> SH);
            now_full = (cnt >= N);
            now_go   = 1;
        end
        @(negedge clk);
        if (pend_go) begin
            exp_ys = pend_ys;
            exp_yc = pend_yc;
            // R2 R3 feed these exact values; R4 / R5 give their form and timing
            check("R4 fund_sin", longint'(fund_sin), longint'($signed(exp_ys)));
            check("R5 fund_cos", longint'(fund_cos), longint'($signed(exp_yc)));
            check("R6 fund_vld", longint'(fund_vld), longint'(pend_full));
            if (pend_tol && pend_full) begin
                n_chk++;
                if (fund_sin > pend_fs + 16 || fund_sin < pend_fs - 16 ||
                    fund_cos > pend_fc + 16 || fund_cos < pend_fc - 16) begin
                    n_bad++;
                    $display("FAIL R8 tone: actual %0d/%0d expected %0d/%0d",
                             fund_sin, fund_cos, pend_fs, pend_fc);
                end
            end
        end else begin
            check("R7 hold sin", longint'(fund_sin), longint'($signed(exp_ys)));
            check("R7 hold cos", longint'(fund_cos), longint'($signed(exp_yc)));
            check("R7 vld low", longint'(fund_vld), 0);
        end
        pend_go = now_go; pend_ys = now_ys; pend_yc = now_yc; pend_full = now_full;
        pend_tol = tol; pend_fs = fs; pend_fc = fc;
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        n_bad++;
        n_chk++;
        $display("FAIL watchdog: actual timeout expected finish");
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

    initial begin
        void'($urandom(32'd7531));
        model_reset();
        do_reset();

        // Tone at the table frequency, shifted by 5 slots, strobes with random gaps (R6 fill, R8)
        for (int i = 0; i < 4 * N; ) begin
            bit st;
            st = ($urandom % 3) != 0;
            if (st) begin
                tick(1, tone(ph + 5, 1500), 1, tone(ph + 5, 1500), tone(ph + 5 + N / 4, 1500));
                i++;
            end else begin
                tick(0, longint'($urandom % 4096) - 2048, 0, 0, 0);
            end
        end

        // Random samples, strobe every cycle
        for (int i = 0; i < 150; i++) begin
            tick(1, longint'($urandom % 4096) - 2048, 0, 0, 0);
        end

        // Most negative constant, then full-scale alternation
        for (int i = 0; i < N + 8; i++) tick(1, -2048, 0, 0, 0);
        for (int i = 0; i < N + 8; i++) tick(1, (i % 2) ? 2047 : -2048, 0, 0, 0);

        // R7: idle stretch with wandering sample values
        for (int i = 0; i < 20; i++) tick(0, longint'($urandom % 4096) - 2048, 0, 0, 0);
        for (int i = 0; i < 10; i++) tick(1, longint'($urandom % 4096) - 2048, 0, 0, 0);

        // Reset mid-run, then refill from scratch (R1, R6)
        do_reset();
        for (int i = 0; i < N + 20; i++) begin
            tick(($urandom % 4) != 0, longint'($urandom % 4096) - 2048, 0, 0, 0);
        end
        tick(0, 0, 0, 0, 0);
        tick(0, 0, 0, 0, 0);

        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end
endmodule